// File: doc/BRIEF.md
# DMA Read Tag Tracker

This block sits between a device's internal DMA engine and the transaction layer that forms link packets. The engine hands it memory read and memory write requests. The block forwards each request as a descriptor toward the link. Writes are posted, so they go straight through with no tag and no tracking. Each read takes the lowest free tag from a pool and holds it until the completions returning under that tag have delivered the full requested byte count. A read may be answered by several completions, and none of them may exceed the maximum payload size.

All request issue is gated by a master-enable control bit. The bit is held in a register that comes out of reset cleared. While it is clear, no read or write leaves the block. Completions for reads that are already outstanding still retire. A completion with a tag that is not outstanding is dropped, and so is one with a malformed byte count. Either case raises a one-cycle error pulse.

Top module: `dma_read_tag_tracker`

## Requirements
- R1: After reset the master-enable bit (`master_en`) reads 0. While it is 0, `out_valid` and `eng_req_ready` stay low for both reads and writes.
- R2: A cycle with `cmd_we` high loads `cmd_master_en` into the master-enable bit, and the new value is visible on `master_en` the following cycle.
- R3: A write (`eng_req_is_write`=1) is forwarded in the same cycle with its address and length. It carries `out_tag`=0 and does not consume a tag.
- R4: A read is forwarded in the same cycle and carries the numerically lowest tag that is not outstanding. The tag is taken only when `out_ready` is high.
- R5: When all 2^TAG_W tags are outstanding, a read is held (`out_valid`=0, `eng_req_ready`=0) while writes still pass.
- R6: A completion whose tag is outstanding and whose byte count is between 1 and MPS_BYTES is delivered one cycle later on `eng_cpl_valid`, with its tag, data and byte count.
- R7: A read retires when its accumulated completion bytes reach or pass its requested length. That completion is delivered with `eng_cpl_last`=1, and the tag can be reused from the next cycle.
- R8: A completion for a tag that is not outstanding is dropped (no `eng_cpl_valid`), and `cpl_err` pulses high for one cycle, one cycle later.
- R9: A completion with a byte count of 0 or above MPS_BYTES is dropped with a `cpl_err` pulse, and the remaining count of its tag is unchanged.
- R10: Clearing the master-enable bit while reads are outstanding blocks new issue, but completions for those reads are still delivered and retired.
- R11: While `out_ready` is low, a forwarded request is not accepted (`eng_req_ready`=0) and no tag is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Write strobe for the master-enable bit |
| cmd_master_en | input | 1 | Value loaded into the master-enable bit |
| master_en | output | 1 | Current master-enable bit |
| eng_req_valid | input | 1 | Engine request present |
| eng_req_is_write | input | 1 | 1 = posted write, 0 = read |
| eng_req_addr | input | ADDR_W | Request address |
| eng_req_len | input | LEN_W | Request length in bytes |
| eng_req_ready | output | 1 | Request accepted this cycle |
| out_valid | output | 1 | Descriptor toward the link is valid |
| out_is_write | output | 1 | Descriptor kind |
| out_addr | output | ADDR_W | Descriptor address |
| out_len | output | LEN_W | Descriptor length |
| out_tag | output | TAG_W | Descriptor tag (0 for writes) |
| out_ready | input | 1 | Link side accepts the descriptor |
| cpl_valid | input | 1 | Completion arriving |
| cpl_tag | input | TAG_W | Completion tag |
| cpl_bytes | input | LEN_W | Completion payload byte count |
| cpl_data | input | DATA_W | Completion data |
| eng_cpl_valid | output | 1 | Matched completion for the engine |
| eng_cpl_tag | output | TAG_W | Its tag |
| eng_cpl_bytes | output | LEN_W | Its byte count |
| eng_cpl_data | output | DATA_W | Its data |
| eng_cpl_last | output | 1 | Read retired with this completion |
| cpl_err | output | 1 | Unexpected or malformed completion pulse |

## Verification
On every cycle the assertions check four things. Issue happens only with the master-enable bit set. A read is never given a tag that is already outstanding. A delivered completion was matched against a live tag, and that tag is freed when the read retires. An error pulse never appears alongside a delivered completion. The directed scenarios show the rest. These are the lowest-tag ordering, tag reuse after retirement, multi-completion accumulation, the full-pool stall with writes still flowing, backpressure that consumes no tag, and completions draining after the enable bit is cleared.

// File: rtl/dmatrk_pkg.sv
package dmatrk_pkg;

    localparam int DEF_TAG_W  = 8;
    localparam int DEF_ADDR_W = 32;
    localparam int DEF_LEN_W  = 13;
    localparam int DEF_DATA_W = 64;
    localparam int DEF_MPS    = 256;

    // Classification of an arriving completion
    typedef enum logic [1:0] {
        CPL_IDLE  = 2'd0,
        CPL_HIT   = 2'd1,
        CPL_STRAY = 2'd2,
        CPL_BAD   = 2'd3
    } cpl_class_e;

    // Request kind
    typedef enum logic {
        KIND_READ  = 1'b0,
        KIND_WRITE = 1'b1
    } req_kind_e;

    function automatic logic size_ok(input int unsigned bytes, input int unsigned mps);
        return (bytes != 0) && (bytes <= mps);
    endfunction

endpackage

// File: rtl/dmatrk_tag_pool.sv
module dmatrk_tag_pool #(
    parameter int TAG_W = 8,
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_en,
    input  logic [LEN_W-1:0] alloc_len,
    output logic             free_avail,
    output logic [TAG_W-1:0] free_tag,
    input  logic [TAG_W-1:0] look_tag,
    input  logic [LEN_W-1:0] look_bytes,
    output logic             look_busy,
    output logic             look_last,
    input  logic             consume,
    output logic [(1<<TAG_W)-1:0] busy_vec
);
    localparam int NTAGS = 1 << TAG_W;

    logic [NTAGS-1:0] busy_q;
    logic [LEN_W-1:0] rem_q [NTAGS];

    // Lowest free tag, scanning from the top so the lowest index wins
    always_comb begin
        free_avail = 1'b0;
        free_tag   = '0;
        for (int i = NTAGS - 1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                free_avail = 1'b1;
                free_tag   = TAG_W'(i);
            end
        end
    end

    assign look_busy = busy_q[look_tag];
    assign look_last = (look_bytes >= rem_q[look_tag]);
    assign busy_vec  = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
        end else begin
            if (alloc_en) busy_q[free_tag] <= 1'b1;
            if (consume && look_last) busy_q[look_tag] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) rem_q[free_tag] <= alloc_len;
        if (consume && !look_last) rem_q[look_tag] <= rem_q[look_tag] - look_bytes;
    end

    a_r4_alloc_only_free: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> (free_avail && !busy_q[free_tag]));

    a_r7_retired_tag_freed: assert property (@(posedge clk) disable iff (rst)
        (consume && look_last) |=> !busy_q[$past(look_tag)]);

endmodule

// File: rtl/dmatrk_issue.sv
module dmatrk_issue #(
    parameter int TAG_W  = 8,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              cmd_master_en,
    output logic              master_en,
    input  logic              req_valid,
    input  logic              req_is_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ready,
    input  logic              tag_avail,
    input  logic [TAG_W-1:0]  tag_next,
    output logic              alloc_en,
    output logic              out_valid,
    output logic              out_is_write,
    output logic [ADDR_W-1:0] out_addr,
    output logic [LEN_W-1:0]  out_len,
    output logic [TAG_W-1:0]  out_tag,
    input  logic              out_ready
);
    import dmatrk_pkg::*;

    logic      en_q;
    req_kind_e kind;
    logic      can_go;

    always_ff @(posedge clk) begin
        if (rst)         en_q <= 1'b0;
        else if (cmd_we) en_q <= cmd_master_en;
    end

    assign master_en = en_q;
    assign kind      = req_is_write ? KIND_WRITE : KIND_READ;

    always_comb begin
        can_go = 1'b0;
        if (req_valid && en_q) begin
            case (kind)
                KIND_WRITE: can_go = 1'b1;
                default:    can_go = tag_avail;
            endcase
        end
    end

    assign out_valid    = can_go;
    assign out_is_write = (kind == KIND_WRITE);
    assign out_addr     = req_addr;
    assign out_len      = req_len;
    assign out_tag      = (kind == KIND_WRITE) ? '0 : tag_next;
    assign req_ready    = can_go && out_ready;
    assign alloc_en     = req_ready && (kind == KIND_READ);

    a_r11_accept_needs_ready: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (out_ready && out_valid));

    a_r3_write_no_alloc: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_write) |-> !alloc_en);

endmodule

// File: rtl/dmatrk_cpl_match.sv
module dmatrk_cpl_match #(
    parameter int TAG_W     = 8,
    parameter int LEN_W     = 13,
    parameter int DATA_W    = 64,
    parameter int MPS_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [LEN_W-1:0]  cpl_bytes,
    input  logic [DATA_W-1:0] cpl_data,
    input  logic              tag_busy,
    input  logic              tag_last,
    output logic              consume,
    output logic              eng_cpl_valid,
    output logic [TAG_W-1:0]  eng_cpl_tag,
    output logic [LEN_W-1:0]  eng_cpl_bytes,
    output logic [DATA_W-1:0] eng_cpl_data,
    output logic              eng_cpl_last,
    output logic              cpl_err
);
    import dmatrk_pkg::*;

    cpl_class_e cls;

    always_comb begin
        cls = CPL_IDLE;
        if (cpl_valid) begin
            if (!size_ok(int'(cpl_bytes), MPS_BYTES)) cls = CPL_BAD;
            else if (!tag_busy)                      cls = CPL_STRAY;
            else                                     cls = CPL_HIT;
        end
    end

    assign consume = (cls == CPL_HIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_cpl_valid <= 1'b0;
            eng_cpl_last  <= 1'b0;
            cpl_err       <= 1'b0;
        end else begin
            eng_cpl_valid <= (cls == CPL_HIT);
            eng_cpl_last  <= (cls == CPL_HIT) && tag_last;
            cpl_err       <= (cls == CPL_STRAY) || (cls == CPL_BAD);
        end
    end

    always_ff @(posedge clk) begin
        if (cls == CPL_HIT) begin
            eng_cpl_tag   <= cpl_tag;
            eng_cpl_bytes <= cpl_bytes;
            eng_cpl_data  <= cpl_data;
        end
    end

    a_r8_err_excludes_delivery: assert property (@(posedge clk) disable iff (rst)
        !(cpl_err && eng_cpl_valid));

    a_r9_bad_size_dropped: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && (cpl_bytes == '0)) |=> (cpl_err && !eng_cpl_valid));

endmodule

// File: rtl/dma_read_tag_tracker.sv
module dma_read_tag_tracker #(
    parameter int TAG_W     = dmatrk_pkg::DEF_TAG_W,
    parameter int ADDR_W    = dmatrk_pkg::DEF_ADDR_W,
    parameter int LEN_W     = dmatrk_pkg::DEF_LEN_W,
    parameter int DATA_W    = dmatrk_pkg::DEF_DATA_W,
    parameter int MPS_BYTES = dmatrk_pkg::DEF_MPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              cmd_master_en,
    output logic              master_en,
    input  logic              eng_req_valid,
    input  logic              eng_req_is_write,
    input  logic [ADDR_W-1:0] eng_req_addr,
    input  logic [LEN_W-1:0]  eng_req_len,
    output logic              eng_req_ready,
    output logic              out_valid,
    output logic              out_is_write,
    output logic [ADDR_W-1:0] out_addr,
    output logic [LEN_W-1:0]  out_len,
    output logic [TAG_W-1:0]  out_tag,
    input  logic              out_ready,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [LEN_W-1:0]  cpl_bytes,
    input  logic [DATA_W-1:0] cpl_data,
    output logic              eng_cpl_valid,
    output logic [TAG_W-1:0]  eng_cpl_tag,
    output logic [LEN_W-1:0]  eng_cpl_bytes,
    output logic [DATA_W-1:0] eng_cpl_data,
    output logic              eng_cpl_last,
    output logic              cpl_err
);
    localparam int NTAGS = 1 << TAG_W;

    logic             alloc_en, tag_avail, tag_busy, tag_last, consume;
    logic [TAG_W-1:0] tag_next;
    logic [NTAGS-1:0] busy_vec;

    dmatrk_issue #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_issue (
        .clk(clk), .rst(rst),
        .cmd_we(cmd_we), .cmd_master_en(cmd_master_en), .master_en(master_en),
        .req_valid(eng_req_valid), .req_is_write(eng_req_is_write),
        .req_addr(eng_req_addr), .req_len(eng_req_len), .req_ready(eng_req_ready),
        .tag_avail(tag_avail), .tag_next(tag_next), .alloc_en(alloc_en),
        .out_valid(out_valid), .out_is_write(out_is_write), .out_addr(out_addr),
        .out_len(out_len), .out_tag(out_tag), .out_ready(out_ready)
    );

    dmatrk_tag_pool #(.TAG_W(TAG_W), .LEN_W(LEN_W)) u_pool (
        .clk(clk), .rst(rst),
        .alloc_en(alloc_en), .alloc_len(eng_req_len),
        .free_avail(tag_avail), .free_tag(tag_next),
        .look_tag(cpl_tag), .look_bytes(cpl_bytes),
        .look_busy(tag_busy), .look_last(tag_last),
        .consume(consume), .busy_vec(busy_vec)
    );

    dmatrk_cpl_match #(.TAG_W(TAG_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
                       .MPS_BYTES(MPS_BYTES)) u_cpl (
        .clk(clk), .rst(rst),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_bytes(cpl_bytes),
        .cpl_data(cpl_data), .tag_busy(tag_busy), .tag_last(tag_last),
        .consume(consume),
        .eng_cpl_valid(eng_cpl_valid), .eng_cpl_tag(eng_cpl_tag),
        .eng_cpl_bytes(eng_cpl_bytes), .eng_cpl_data(eng_cpl_data),
        .eng_cpl_last(eng_cpl_last), .cpl_err(cpl_err)
    );

    a_r1_issue_needs_enable: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> master_en);

    a_r5_full_pool_holds_reads: assert property (@(posedge clk) disable iff (rst)
        ((&busy_vec) && eng_req_valid && !eng_req_is_write) |-> !out_valid);

    a_r6_delivered_was_live: assert property (@(posedge clk) disable iff (rst)
        (eng_cpl_valid && !eng_cpl_last) |-> busy_vec[eng_cpl_tag]);

    a_r4_read_tag_not_live: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_write) |-> !busy_vec[out_tag]);

endmodule

// File: tb/sim_dma_read_tag_tracker.sv
module sim_dma_read_tag_tracker;
    localparam int TAG_W = 8, ADDR_W = 32, LEN_W = 13, DATA_W = 64, MPS = 256;
    localparam int NTAGS = 1 << TAG_W;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_we = 0, cmd_master_en = 0, master_en;
    logic eng_req_valid = 0, eng_req_is_write = 0, eng_req_ready;
    logic [ADDR_W-1:0] eng_req_addr = '0, out_addr;
    logic [LEN_W-1:0]  eng_req_len = '0, out_len;
    logic out_valid, out_is_write, out_ready = 1'b1;
    logic [TAG_W-1:0] out_tag;
    logic cpl_valid = 0;
    logic [TAG_W-1:0] cpl_tag = '0, eng_cpl_tag;
    logic [LEN_W-1:0] cpl_bytes = '0, eng_cpl_bytes;
    logic [DATA_W-1:0] cpl_data = '0, eng_cpl_data;
    logic eng_cpl_valid, eng_cpl_last, cpl_err;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dma_read_tag_tracker u0 (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_master_en(cmd_master_en),
        .master_en(master_en), .eng_req_valid(eng_req_valid),
        .eng_req_is_write(eng_req_is_write), .eng_req_addr(eng_req_addr),
        .eng_req_len(eng_req_len), .eng_req_ready(eng_req_ready),
        .out_valid(out_valid), .out_is_write(out_is_write), .out_addr(out_addr),
        .out_len(out_len), .out_tag(out_tag), .out_ready(out_ready),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_bytes(cpl_bytes),
        .cpl_data(cpl_data), .eng_cpl_valid(eng_cpl_valid),
        .eng_cpl_tag(eng_cpl_tag), .eng_cpl_bytes(eng_cpl_bytes),
        .eng_cpl_data(eng_cpl_data), .eng_cpl_last(eng_cpl_last), .cpl_err(cpl_err)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_en(input logic v);
        @(negedge clk); cmd_we = 1; cmd_master_en = v;
        @(negedge clk); cmd_we = 0;
    endtask

    // Present a request for one cycle; report combinational outputs
    task automatic req(input logic wr, input logic [LEN_W-1:0] len,
                       output logic ov, output logic rdy, output logic [TAG_W-1:0] tg);
        @(negedge clk);
        eng_req_valid = 1; eng_req_is_write = wr; eng_req_len = len;
        eng_req_addr = 32'h1000_0000 + len;
        #1; ov = out_valid; rdy = eng_req_ready; tg = out_tag;
        @(negedge clk); eng_req_valid = 0;
    endtask

    // Present one completion; report registered outputs one cycle later
    task automatic cpl(input logic [TAG_W-1:0] t, input logic [LEN_W-1:0] b,
                       input logic [DATA_W-1:0] d,
                       output logic v, output logic last, output logic err);
        @(negedge clk);
        cpl_valid = 1; cpl_tag = t; cpl_bytes = b; cpl_data = d;
        @(negedge clk); cpl_valid = 0;
        #1; v = eng_cpl_valid; last = eng_cpl_last; err = cpl_err;
    endtask

    task automatic t_reset();
        logic ov, rdy; logic [TAG_W-1:0] tg;
        chk("R1", "master_en after reset", master_en, 0);
        req(0, 16, ov, rdy, tg);
        chk("R1", "read out_valid while off", ov, 0);
        chk("R1", "read ready while off", rdy, 0);
        req(1, 16, ov, rdy, tg);
        chk("R1", "write out_valid while off", ov, 0);
    endtask

    task automatic t_enable();
        @(negedge clk); cmd_we = 1; cmd_master_en = 1;
        #1; chk("R2", "master_en before edge", master_en, 0);
        @(negedge clk); cmd_we = 0;
        #1; chk("R2", "master_en after load", master_en, 1);
    endtask

    task automatic t_write();
        @(negedge clk);
        eng_req_valid = 1; eng_req_is_write = 1; eng_req_len = 40; eng_req_addr = 32'hABCD_0040;
        #1;
        chk("R3", "write out_valid", out_valid, 1);
        chk("R3", "write ready", eng_req_ready, 1);
        chk("R3", "write kind", out_is_write, 1);
        chk("R3", "write addr", out_addr, 32'hABCD_0040);
        chk("R3", "write len", out_len, 40);
        chk("R3", "write tag", out_tag, 0);
        @(negedge clk); eng_req_valid = 0;
    endtask

    task automatic t_reads_and_retire();
        logic ov, rdy, v, last, err; logic [TAG_W-1:0] tg;
        req(0, 100, ov, rdy, tg);
        chk("R4", "first read tag (write took none)", tg, 0);
        chk("R4", "first read ready", rdy, 1);
        req(0, 64, ov, rdy, tg);
        chk("R4", "second read lowest tag", tg, 1);
        cpl(1, 64, 64'hDEAD_BEEF_0000_0001, v, last, err);
        chk("R6", "delivered valid", v, 1);
        chk("R6", "delivered tag", eng_cpl_tag, 1);
        chk("R6", "delivered data", eng_cpl_data, 64'hDEAD_BEEF_0000_0001);
        chk("R6", "delivered bytes", eng_cpl_bytes, 64);
        chk("R7", "single completion last", last, 1);
        req(0, 32, ov, rdy, tg);
        chk("R7", "retired tag reused", tg, 1);
        cpl(0, 60, 64'h11, v, last, err);
        chk("R7", "partial completion valid", v, 1);
        chk("R7", "partial completion not last", last, 0);
        cpl(0, 40, 64'h22, v, last, err);
        chk("R7", "final completion last", last, 1);
    endtask

    task automatic t_unexpected();
        logic v, last, err;
        cpl(5, 8, 64'h33, v, last, err);
        chk("R8", "stray not delivered", v, 0);
        chk("R8", "stray error pulse", err, 1);
        @(negedge clk); #1;
        chk("R8", "error pulse one cycle", cpl_err, 0);
    endtask

    task automatic t_bad_size();
        logic v, last, err;
        cpl(1, LEN_W'(MPS + 1), 64'h44, v, last, err);
        chk("R9", "oversize not delivered", v, 0);
        chk("R9", "oversize error", err, 1);
        cpl(1, 0, 64'h45, v, last, err);
        chk("R9", "zero-size error", err, 1);
        cpl(1, 32, 64'h46, v, last, err);
        chk("R9", "count unchanged, retires at full length", last, 1);
    endtask

    task automatic t_backpressure();
        logic ov, rdy, v, last, err; logic [TAG_W-1:0] tg;
        out_ready = 0;
        req(0, 24, ov, rdy, tg);
        chk("R11", "valid under backpressure", ov, 1);
        chk("R11", "not accepted", rdy, 0);
        out_ready = 1;
        req(0, 24, ov, rdy, tg);
        chk("R11", "tag not consumed", tg, 0);
        cpl(0, 24, 64'h55, v, last, err);
        chk("R11", "cleanup retire", last, 1);
    endtask

    task automatic t_disable_drain();
        logic ov, rdy, v, last, err; logic [TAG_W-1:0] tg;
        req(0, 16, ov, rdy, tg);
        chk("R10", "read before disable", tg, 0);
        set_en(0);
        req(0, 16, ov, rdy, tg);
        chk("R10", "read blocked when off", ov, 0);
        req(1, 16, ov, rdy, tg);
        chk("R10", "write blocked when off", ov, 0);
        cpl(0, 16, 64'h66, v, last, err);
        chk("R10", "outstanding completion delivered", v, 1);
        chk("R10", "outstanding read retired", last, 1);
        set_en(1);
    endtask

    task automatic t_full();
        logic ov, rdy, v, last, err; logic [TAG_W-1:0] tg;
        int bad = 0;
        for (int i = 0; i < NTAGS; i++) begin
            req(0, 8, ov, rdy, tg);
            if (!rdy || tg != TAG_W'(i)) bad++;
        end
        chk("R4", "ascending tags while filling", bad, 0);
        req(0, 8, ov, rdy, tg);
        chk("R5", "read held when full (valid)", ov, 0);
        chk("R5", "read held when full (ready)", rdy, 0);
        req(1, 8, ov, rdy, tg);
        chk("R5", "write passes when full", rdy, 1);
        cpl(7, 8, 64'h77, v, last, err);
        chk("R5", "free one tag", last, 1);
        req(0, 8, ov, rdy, tg);
        chk("R5", "freed tag handed out", tg, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        t_reset();
        t_enable();
        t_write();
        t_reads_and_retire();
        t_unexpected();
        t_bad_size();
        t_backpressure();
        t_disable_drain();
        t_full();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule